// File: doc/BRIEF.md
# SDRAM Bank Window Address Decoder

This block takes a 32-bit system address and finds which of several SDRAM banks, if any, claims it. Each bank is described by one 32-bit configuration word that carries an 8 MiB-aligned base address, a 3-bit power-of-two size code and a valid bit. A bank claims an address only while the controller-wide enable and the bank's own valid bit are both set and the address lies inside the bank's window.

The decode is purely combinational. It reports a hit flag, a one-hot bank select, the binary bank index and the offset of the address relative to the selected bank's base. When windows overlap, the bank with the lowest index is chosen. The configuration words and the enable are held by surrounding logic; this block only interprets them, so clearing the enable withdraws every window at once, and setting it again brings back the stored windows unchanged.

Top module: `bwd_window_decode`

## Requirements
- R1: The bank base is the configuration word with bits 22:0 forced to zero (bits 31:23 kept, 8 MiB granularity); an address below the base never hits that bank.
- R2: The size code sits in bits 19:17; the window size is 4 MiB shifted left by the code, so codes 0 to 6 give 4, 8, 16, 32, 64, 128 and 256 MiB, and an address at or above base plus size does not hit.
- R3: A bank whose size code is 7 never produces a hit, whatever its other fields.
- R4: Bit 0 of the configuration word is the bank valid bit; a bank with this bit at 0 never hits.
- R5: While enable_i is 0 no bank hits; when enable_i returns to 1 the unchanged configuration words decode exactly as before.
- R6: The end of a window is computed without wraparound: a window that would extend past 4 GiB covers addresses up to 0xFFFFFFFF and never addresses near 0.
- R7: When more than one bank matches, the lowest-numbered bank is selected.
- R8: With no matching bank, hit_o is 0, bank_sel_o is all zeros, bank_idx_o is 0 and offset_o is 0.
- R9: On a hit, bank_sel_o has exactly bit bank_idx_o set and offset_o equals the address minus the selected bank's base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bank_cfg_i | input | NUM_BANKS x 32 | Configuration word per bank: base in 31:23, size code in 19:17, valid in bit 0 |
| enable_i | input | 1 | Controller-wide enable; 0 withdraws every bank window |
| addr_i | input | 32 | System address to decode |
| hit_o | output | 1 | Some bank claims the address |
| bank_sel_o | output | NUM_BANKS | One-hot select of the claiming bank, zero on a miss |
| bank_idx_o | output | IDX_W | Index of the claiming bank, zero on a miss |
| offset_o | output | 32 | Address minus the claiming bank's base, zero on a miss |

## Verification
The checks on the outputs assume only that the inputs are settled two-state values; the block has no state, so nothing is assumed about the order or timing of input changes. The bench changes configuration words, enable and address only away from the sampling instant and samples after a short settling delay, so every check sees a stable combinational result. Stimulus places addresses exactly on window edges, in the top 8 MiB of the space and inside overlapping windows, while all unused banks are held invalid so each expected result depends on the banks a test sets up.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int BASE_LSB   = 23;
    localparam int CODE_LSB   = 17;
    localparam int CODE_W     = 3;
    localparam int VALID_BIT  = 0;
    localparam int UNIT_LOG2  = 22;
    localparam logic [CODE_W-1:0] CODE_RESERVED = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   limit;
        logic              usable;
    } window_t;

    function automatic logic [ADDR_W:0] window_size(input logic [CODE_W-1:0] code);
        return (ADDR_W+1)'(1) << (UNIT_LOG2 + int'(code));
    endfunction

    function automatic window_t unpack_window(input logic [WORD_W-1:0] word);
        window_t w;
        logic [CODE_W-1:0] code;
        code     = word[CODE_LSB +: CODE_W];
        w.base   = {word[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
        w.limit  = {1'b0, w.base} + window_size(code);
        w.usable = word[VALID_BIT] && (code != CODE_RESERVED);
        return w;
    endfunction

endpackage

// File: rtl/bwd_bank_match.sv
module bwd_bank_match
    import bwd_pkg::*;
(
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic              enable_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              match_o,
    output logic [ADDR_W-1:0] offset_o
);

    window_t win;
    logic    above_base;
    logic    below_limit;
    logic    unused_fields;

    assign unused_fields = ^{cfg_word_i[BASE_LSB-1:CODE_LSB+CODE_W],
                             cfg_word_i[CODE_LSB-1:VALID_BIT+1]};

    always_comb begin
        win         = unpack_window(cfg_word_i);
        above_base  = addr_i >= win.base;
        below_limit = {1'b0, addr_i} < win.limit;
        match_o     = enable_i && win.usable && above_base && below_limit;
        offset_o    = addr_i - win.base;
    end

endmodule

// File: rtl/bwd_prio_select.sv
module bwd_prio_select
    import bwd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS-1:0]             match_i,
    input  logic [NUM_BANKS-1:0][ADDR_W-1:0] offset_i,
    output logic                             hit_o,
    output logic [NUM_BANKS-1:0]             sel_o,
    output logic [IDX_W-1:0]                 idx_o,
    output logic [ADDR_W-1:0]                offset_o
);

    always_comb begin
        hit_o    = 1'b0;
        sel_o    = '0;
        idx_o    = '0;
        offset_o = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (match_i[i] && !hit_o) begin
                hit_o    = 1'b1;
                sel_o[i] = 1'b1;
                idx_o    = IDX_W'(i);
                offset_o = offset_i[i];
            end
        end
    end

endmodule

// File: rtl/bwd_window_decode.sv
module bwd_window_decode
    import bwd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_cfg_i,
    input  logic                             enable_i,
    input  logic [ADDR_W-1:0]                addr_i,
    output logic                             hit_o,
    output logic [NUM_BANKS-1:0]             bank_sel_o,
    output logic [IDX_W-1:0]                 bank_idx_o,
    output logic [ADDR_W-1:0]                offset_o
);

    logic [NUM_BANKS-1:0]             bank_match;
    logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_offset;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bwd_bank_match u_match (
            .cfg_word_i (bank_cfg_i[b]),
            .enable_i   (enable_i),
            .addr_i     (addr_i),
            .match_o    (bank_match[b]),
            .offset_o   (bank_offset[b])
        );
    end

    bwd_prio_select #(
        .NUM_BANKS (NUM_BANKS)
    ) u_select (
        .match_i  (bank_match),
        .offset_i (bank_offset),
        .hit_o    (hit_o),
        .sel_o    (bank_sel_o),
        .idx_o    (bank_idx_o),
        .offset_o (offset_o)
    );

endmodule

// File: rtl/bwd_window_decode_chk.sv
module bwd_window_decode_chk
    import bwd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic [NUM_BANKS-1:0][WORD_W-1:0] bank_cfg_i,
    input logic                             enable_i,
    input logic [ADDR_W-1:0]                addr_i,
    input logic                             hit_o,
    input logic [NUM_BANKS-1:0]             bank_sel_o,
    input logic [IDX_W-1:0]                 bank_idx_o,
    input logic [ADDR_W-1:0]                offset_o
);

    window_t chosen;

    always_comb begin
        chosen = unpack_window(bank_cfg_i[bank_idx_o]);

        // R5
        off_means_miss_chk: assert (enable_i || !hit_o)
            else $error("hit while controller disabled");

        // R9
        sel_onehot_chk: assert ($onehot0(bank_sel_o) && (hit_o == (bank_sel_o != '0)))
            else $error("select not one-hot or disagrees with hit");

        if (hit_o) begin
            // R9
            sel_matches_idx_chk: assert (bank_sel_o[bank_idx_o])
                else $error("select bit and index disagree");
            // R3
            // R4
            usable_bank_chk: assert (chosen.usable)
                else $error("hit on invalid or reserved-size bank");
            // R6
            no_overflow_chk: assert ({1'b0, addr_i} < chosen.limit && addr_i >= chosen.base)
                else $error("address outside selected window");
            // R9
            offset_sum_chk: assert (offset_o + chosen.base == addr_i)
                else $error("offset plus base differs from address");
        end else begin
            // R8
            miss_zero_chk: assert (bank_idx_o == '0 && offset_o == '0)
                else $error("nonzero index or offset on a miss");
        end
    end

endmodule

bind bwd_window_decode bwd_window_decode_chk #(
    .NUM_BANKS (NUM_BANKS)
) chk_i (
    .bank_cfg_i (bank_cfg_i),
    .enable_i   (enable_i),
    .addr_i     (addr_i),
    .hit_o      (hit_o),
    .bank_sel_o (bank_sel_o),
    .bank_idx_o (bank_idx_o),
    .offset_o   (offset_o)
);

// File: tb/bwd_window_decode_tb_top.sv
module bwd_window_decode_tb_top;

    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NB-1:0][31:0] cfg = '0;
    logic              en = 1'b0;
    logic [31:0]       addr = '0;
    logic              hit;
    logic [NB-1:0]     sel;
    logic [1:0]        idx;
    logic [31:0]       off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bwd_window_decode #(.NUM_BANKS(NB)) dut_i (
        .bank_cfg_i (cfg),
        .enable_i   (en),
        .addr_i     (addr),
        .hit_o      (hit),
        .bank_sel_o (sel),
        .bank_idx_o (idx),
        .offset_o   (off)
    );

    function automatic logic [31:0] mk(input logic [31:0] base, input int code, input bit valid);
        return (base & 32'hFF80_0000) | (32'(code) << 17) | 32'(valid);
    endfunction

    task automatic expect_at(input string tag, input logic [31:0] a,
                             input bit eh, input int eidx, input logic [31:0] eoff);
        logic [NB-1:0] esel;
        @(negedge clk);
        addr = a;
        #1;
        esel = eh ? (NB'(1) << eidx) : '0;
        if (!eh) eidx = 0;
        checks++;
        if (hit !== eh || sel !== esel || int'(idx) != eidx || off !== eoff) begin
            fails++;
            $display("FAIL %s addr=%h: hit=%0b sel=%b idx=%0d off=%h expected hit=%0b sel=%b idx=%0d off=%h",
                     tag, a, hit, sel, idx, off, eh, esel, eidx, eoff);
        end
    endtask

    task automatic set_bank(input int b, input logic [31:0] w);
        @(negedge clk);
        cfg[b] = w;
    endtask

    task automatic clear_all();
        @(negedge clk);
        cfg = '0;
        en  = 1'b1;
    endtask

    task automatic t_reset_state();
        expect_at("R8 reset, all off", 32'h0000_0000, 0, 0, 0);
        @(negedge clk); en = 1'b1;
        expect_at("R4 R8 enabled, all words zero", 32'h0000_0000, 0, 0, 0);
    endtask

    task automatic t_edges();
        clear_all();
        set_bank(1, mk(32'h1000_0000, 1, 1));
        expect_at("R1 R9 base of 8MiB bank", 32'h1000_0000, 1, 1, 32'h0);
        expect_at("R2 R9 last byte of 8MiB bank", 32'h107F_FFFF, 1, 1, 32'h007F_FFFF);
        expect_at("R2 one past end", 32'h1080_0000, 0, 0, 0);
        expect_at("R1 one below base", 32'h0FFF_FFFF, 0, 0, 0);
        set_bank(0, mk(32'h0000_0000, 0, 1));
        expect_at("R2 4MiB code 0 last byte", 32'h003F_FFFF, 1, 0, 32'h003F_FFFF);
        expect_at("R2 4MiB code 0 end", 32'h0040_0000, 0, 0, 0);
        set_bank(3, mk(32'h2000_0000, 5, 1));
        expect_at("R2 128MiB code 5 inside", 32'h27FF_FFF0, 1, 3, 32'h07FF_FFF0);
        expect_at("R2 128MiB code 5 end", 32'h2800_0000, 0, 0, 0);
    endtask

    task automatic t_reserved_code();
        clear_all();
        set_bank(2, mk(32'h2000_0000, 7, 1));
        expect_at("R3 code 7 at base", 32'h2000_0000, 0, 0, 0);
        expect_at("R3 code 7 far inside", 32'h2100_0000, 0, 0, 0);
    endtask

    task automatic t_valid_bit();
        clear_all();
        set_bank(3, mk(32'h3000_0000, 2, 0));
        expect_at("R4 valid bit clear", 32'h3000_1234, 0, 0, 0);
        set_bank(3, mk(32'h3000_0000, 2, 1));
        expect_at("R4 valid bit set", 32'h3000_1234, 1, 3, 32'h0000_1234);
    endtask

    task automatic t_global_enable();
        clear_all();
        set_bank(1, mk(32'h5000_0000, 3, 1));
        expect_at("R5 enabled before toggle", 32'h5100_0000, 1, 1, 32'h0100_0000);
        @(negedge clk); en = 1'b0;
        expect_at("R5 disabled withdraws window", 32'h5100_0000, 0, 0, 0);
        @(negedge clk); en = 1'b1;
        expect_at("R5 re-enable restores window", 32'h5100_0000, 1, 1, 32'h0100_0000);
    endtask

    task automatic t_top_of_space();
        clear_all();
        set_bank(0, mk(32'hFF80_0000, 6, 1));
        expect_at("R6 top address hits", 32'hFFFF_FFFF, 1, 0, 32'h007F_FFFF);
        expect_at("R6 address 0 no wrap", 32'h0000_0000, 0, 0, 0);
        expect_at("R6 wrapped range no hit", 32'h0E00_0000, 0, 0, 0);
    endtask

    task automatic t_overlap();
        clear_all();
        set_bank(0, mk(32'h4000_0000, 6, 1));
        set_bank(2, mk(32'h4080_0000, 1, 1));
        expect_at("R7 bank 0 wins over bank 2", 32'h4080_0010, 1, 0, 32'h0080_0010);
        set_bank(0, mk(32'h4000_0000, 6, 0));
        expect_at("R7 bank 2 once bank 0 invalid", 32'h4080_0010, 1, 2, 32'h0000_0010);
        set_bank(1, mk(32'h6000_0000, 3, 1));
        set_bank(3, mk(32'h6000_0000, 3, 1));
        expect_at("R7 bank 1 wins over bank 3", 32'h6000_0100, 1, 1, 32'h0000_0100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset_state();
        t_edges();
        t_reserved_code();
        t_valid_bit();
        t_global_enable();
        t_top_of_space();
        t_overlap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule